// File: doc/BRIEF.md
# Physical memory protection access checker

This block decides whether a single memory access may proceed, given the full set of protection entries. Each entry contributes an 8-bit configuration byte and an address register. From these the block works out the byte range each entry guards. It then compares the first and last bytes of the access against every range. The lowest-numbered entry that claims either byte settles the outcome. The decision is one allow bit.

The entries arrive as flattened input ports, so the block holds no configuration storage of its own. A core would drive them from its control registers. It would present the access address, the access size in bytes, the requested rights and the current privilege level. Address registers hold a byte address divided by four. Comparisons therefore use physical addresses two bits wider than the register. The decision comes out combinationally and, by default, through one output register.

Top module: `pmpchk`

## Requirements
- R1: When every entry's mode field is 0 (off), every access is allowed, whatever the rights and privilege.
- R2: Encodings: configuration bits [4:3] select the mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two); bits 0, 1, 2 grant read, write, execute; bit 7 is the lock. Requests use the same bit positions. Privilege value 3 is machine mode.
- R3: In top-of-range mode an entry guards bytes from (previous entry's register << 2) to (own register << 2) − 1. Entry 0 takes 0 as its previous register. When the own register is not above the previous one, the entry guards nothing.
- R4: In four-byte mode an entry guards exactly the 4 bytes starting at (register << 2).
- R5: In power-of-two mode, with k trailing ones in the register, the entry guards 2^(k+3) bytes starting at the register with its low k bits cleared, shifted left by 2. A register of all ones guards the whole address space.
- R6: The last byte of an access is address + size − 1. A size of 0 means the last byte is the final byte of the 4 KiB page that holds the address.
- R7: Entries are examined from index 0 upward, and the first entry that contains either end byte decides.
- R8: If that deciding entry contains exactly one of the two end bytes, the access is denied, in every privilege mode.
- R9: If the deciding entry contains both end bytes, the access is allowed only when every requested right is granted. Outside machine mode the granted rights are configuration bits [2:0].
- R10: In machine mode a deciding entry grants all rights unless it is locked. An entry is locked when its own lock bit is set, or when the next entry has its lock bit set and is in top-of-range mode. A locked entry grants only its configuration bits.
- R11: When at least one entry is active and none contains either end byte, machine-mode accesses are allowed and all other accesses are denied.
- R12: With the output register enabled, the decision appears one clock after its inputs. During reset the output is 0 (deny).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_cfg | input | 8*N | Configuration byte of entry i at bits [8i+7:8i] |
| ent_addr | input | XLEN*N | Address register of entry i at bits [XLEN*i +: XLEN] |
| acc_addr | input | XLEN+2 | Byte address of the access |
| acc_size | input | XLEN+2 | Access size in bytes, 0 meaning up to the end of the page |
| acc_req | input | 3 | Requested rights: bit0 read, bit1 write, bit2 execute |
| acc_priv | input | 2 | Current privilege level, 3 is machine mode |
| allow | output | 1 | 1 when the access may proceed |

## Verification
On every cycle the assertions check four things. With no active entry, the access is allowed. A partial hit in the lowest claiming entry is denied. An empty request against a full hit is allowed. The no-hit default follows the privilege mode. The registered output also equals the combinational decision from the cycle before. The bench's scenarios cover the rest. These are the range arithmetic of each mode, including the empty top-of-range case and the all-ones power-of-two case. They also cover the size-zero page extension, priority between overlapping entries, and how locking, including a lock taken from the next entry, removes machine-mode rights. Only known stimuli with hand-worked ranges show that these come out right.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  localparam int          CFG_W    = 8;
  localparam int          LOCK_BIT = 7;
  localparam logic [1:0]  PRIV_M   = 2'd3;

  function automatic amode_e cfg_mode(input logic [CFG_W-1:0] c);
    return amode_e'(c[4:3]);
  endfunction

  function automatic logic cfg_lock(input logic [CFG_W-1:0] c);
    return c[LOCK_BIT];
  endfunction

endpackage

// File: rtl/pmpchk_range.sv
module pmpchk_range
  import pmpchk_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = XLEN + 2
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [XLEN-1:0]  this_reg,
  input  logic [XLEN-1:0]  prev_reg,
  input  logic [AW-1:0]    first_b,
  input  logic [AW-1:0]    last_b,
  output logic             active,
  output logic             hit,
  output logic             part
);

  function automatic int trail_ones(input logic [XLEN-1:0] a);
    int  n;
    logic run;
    n   = 0;
    run = 1'b1;
    for (int i = 0; i < XLEN; i++) begin
      if (run && a[i]) n = n + 1;
      else             run = 1'b0;
    end
    return n;
  endfunction

  function automatic logic [AW-1:0] low_mask(input int w);
    logic [AW-1:0] m;
    for (int i = 0; i < AW; i++) m[i] = (i < w);
    return m;
  endfunction

  logic [AW-1:0] lo, hi, nmask;
  logic          empty;
  logic          s_in, e_in;

  always_comb begin
    lo    = '0;
    hi    = '0;
    empty = 1'b1;
    nmask = low_mask(trail_ones(this_reg) + 3);
    unique case (cfg_mode(cfg))
      AM_TOR: begin
        lo    = {prev_reg, 2'b00};
        hi    = {this_reg, 2'b00} - AW'(1);
        empty = (this_reg <= prev_reg);
      end
      AM_NA4: begin
        lo    = {this_reg, 2'b00};
        hi    = {this_reg, 2'b11};
        empty = 1'b0;
      end
      AM_NAPOT: begin
        empty = 1'b0;
        if (&this_reg) begin
          lo = '0;
          hi = '1;
        end else begin
          lo = {this_reg, 2'b00} & ~nmask;
          hi = {this_reg, 2'b00} |  nmask;
        end
      end
      default: empty = 1'b1;
    endcase
  end

  assign s_in   = !empty && (first_b >= lo) && (first_b <= hi);
  assign e_in   = !empty && (last_b  >= lo) && (last_b  <= hi);
  assign active = (cfg_mode(cfg) != AM_OFF);
  assign hit    = s_in & e_in;
  assign part   = s_in ^ e_in;

endmodule

// File: rtl/pmpchk_prio.sv
module pmpchk_prio #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   hit_vec,
  input  logic [N-1:0]   part_vec,
  input  logic [3*N-1:0] grant_flat,
  input  logic [2:0]     req,
  input  logic           any_active,
  input  logic           is_m,
  output logic           win_found,
  output logic [IW-1:0]  win_idx,
  output logic           allow
);

  logic [2:0] win_grant;

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!win_found && (hit_vec[i] || part_vec[i])) begin
        win_found = 1'b1;
        win_idx   = IW'(i);
      end
    end
  end

  assign win_grant = grant_flat[win_idx*3 +: 3];

  always_comb begin
    if (!win_found)             allow = is_m || !any_active;
    else if (part_vec[win_idx]) allow = 1'b0;
    else                        allow = ((req & ~win_grant) == 3'b000);
  end

endmodule

// File: rtl/pmpchk.sv
module pmpchk
  import pmpchk_pkg::*;
#(
  parameter int N         = 4,
  parameter int XLEN      = 32,
  parameter int PAGE_BITS = 12,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W*N-1:0]  ent_cfg,
  input  logic [XLEN*N-1:0]   ent_addr,
  input  logic [XLEN+1:0]     acc_addr,
  input  logic [XLEN+1:0]     acc_size,
  input  logic [2:0]          acc_req,
  input  logic [1:0]          acc_priv,
  output logic                allow
);

  localparam int AW = XLEN + 2;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  logic [AW-1:0]  first_b, last_b;
  logic [N-1:0]   act_vec, hit_vec, part_vec, locked;
  logic [3*N-1:0] grant_flat;
  logic           any_active, is_m, allow_comb, win_found;
  logic [IW-1:0]  win_idx;

  assign is_m       = (acc_priv == PRIV_M);
  assign first_b    = acc_addr;
  assign last_b     = (acc_size == '0) ? (acc_addr | PAGE_MASK)
                                       : (acc_addr + acc_size - AW'(1));
  assign any_active = |act_vec;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [CFG_W-1:0] c;
    logic [XLEN-1:0]  prev;
    assign c = ent_cfg[g*CFG_W +: CFG_W];

    if (g == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = ent_addr[(g-1)*XLEN +: XLEN];
    end

    if (g + 1 < N) begin : g_nxt
      logic [CFG_W-1:0] cn;
      assign cn        = ent_cfg[(g+1)*CFG_W +: CFG_W];
      assign locked[g] = cfg_lock(c) || (cfg_lock(cn) && cfg_mode(cn) == AM_TOR);
    end else begin : g_top
      assign locked[g] = cfg_lock(c);
    end

    assign grant_flat[g*3 +: 3] = (is_m && !locked[g]) ? 3'b111 : c[2:0];

    pmpchk_range #(.XLEN(XLEN), .AW(AW)) u_rng (
      .cfg      (c),
      .this_reg (ent_addr[g*XLEN +: XLEN]),
      .prev_reg (prev),
      .first_b  (first_b),
      .last_b   (last_b),
      .active   (act_vec[g]),
      .hit      (hit_vec[g]),
      .part     (part_vec[g])
    );
  end

  pmpchk_prio #(.N(N), .IW(IW)) u_prio (
    .hit_vec    (hit_vec),
    .part_vec   (part_vec),
    .grant_flat (grant_flat),
    .req        (acc_req),
    .any_active (any_active),
    .is_m       (is_m),
    .win_found  (win_found),
    .win_idx    (win_idx),
    .allow      (allow_comb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) allow <= 1'b0;
      else        allow <= allow_comb;
    end
  end else begin : g_comb
    assign allow = allow_comb;
  end

endmodule

// File: rtl/pmpchk_sva.sv
module pmpchk_sva #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] part_vec,
  input logic         any_active,
  input logic         allow_comb,
  input logic         allow,
  input logic [2:0]   acc_req,
  input logic [1:0]   acc_priv
);

  logic [N-1:0] claim, first;
  logic         past_ok;

  assign claim = hit_vec | part_vec;
  assign first = claim & (~claim + N'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  a_r1_no_rules_allow: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |-> allow_comb);

  // R8
  a_r8_partial_deny: assert property (@(posedge clk) disable iff (!rst_n)
    ((first & part_vec) != '0) |-> !allow_comb);

  // R9
  a_r9_empty_req_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (((first & hit_vec) != '0) && (acc_req == 3'b000)) |-> allow_comb);

  // R11
  a_r11_nohit_default: assert property (@(posedge clk) disable iff (!rst_n)
    ((claim == '0) && any_active) |-> (allow_comb == (acc_priv == 2'd3)));

  if (REG_OUT) begin : g_r12
    a_r12_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (allow == $past(allow_comb)));
  end

endmodule

bind pmpchk pmpchk_sva #(.N(N), .REG_OUT(REG_OUT)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_vec    (hit_vec),
  .part_vec   (part_vec),
  .any_active (any_active),
  .allow_comb (allow_comb),
  .allow      (allow),
  .acc_req    (acc_req),
  .acc_priv   (acc_priv)
);

// File: tb/sim_pmpchk.sv
`timescale 1ns/1ps
module sim_pmpchk;

  localparam int N = 4;
  localparam int XLEN = 32;
  localparam int AW = XLEN + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [8*N-1:0]    ent_cfg;
  logic [XLEN*N-1:0] ent_addr;
  logic [AW-1:0]     acc_addr, acc_size;
  logic [2:0]        acc_req;
  logic [1:0]        acc_priv;
  logic              allow;

  int total = 0;
  int bad   = 0;

  logic [7:0]      cf [N];
  logic [XLEN-1:0] ad [N];

  always #4 clk = ~clk;

  pmpchk #(.N(N), .XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .ent_cfg(ent_cfg), .ent_addr(ent_addr),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_req(acc_req),
    .acc_priv(acc_priv), .allow(allow)
  );

  // R2 encodings: mode at [4:3], R/W/X at bits 0/1/2, lock at bit 7
  localparam logic [1:0] M_OFF = 2'd0, M_TOR = 2'd1, M_NA4 = 2'd2, M_NAPOT = 2'd3;
  localparam logic [2:0] RD = 3'b001, WR = 3'b010, EX = 3'b100;
  localparam logic [1:0] PU = 2'd0, PM = 2'd3;

  function automatic logic [7:0] mk(input logic [1:0] m, input logic [2:0] p, input logic l);
    return {l, 2'b00, m, p};
  endfunction

  task automatic clear_ents();
    for (int i = 0; i < N; i++) begin cf[i] = 8'h00; ad[i] = '0; end
  endtask

  task automatic check(input logic exp, input string tag);
    total++;
    if (allow !== exp) begin
      bad++;
      $display("FAIL %s: allow=%0b expected=%0b", tag, allow, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] s,
                       input logic [2:0] r, input logic [1:0] p);
    for (int i = 0; i < N; i++) begin
      ent_cfg[i*8 +: 8]       = cf[i];
      ent_addr[i*XLEN +: XLEN] = ad[i];
    end
    acc_addr = a; acc_size = s; acc_req = r; acc_priv = p;
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [AW-1:0] s,
                       input logic [2:0] r, input logic [1:0] p,
                       input logic exp, input string tag);
    @(negedge clk);
    drive(a, s, r, p);
    @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic t_reset();
    clear_ents();
    cf[0] = mk(M_NAPOT, 3'b111, 1'b0); ad[0] = '1;
    drive(34'h100, 34'd4, RD, PM);
    repeat (3) @(negedge clk);
    check(1'b0, "R12 reset output");
    rst_n = 1'b1;
  endtask

  task automatic t_none();
    clear_ents();
    probe(34'h100, 34'd4, WR, PU, 1'b1, "R1 no rules user write");
    probe(34'h3_0000_0000, 34'd8, EX, PU, 1'b1, "R1 no rules user exec");
  endtask

  task automatic t_tor();
    clear_ents();
    cf[0] = mk(M_TOR, RD, 1'b0);      ad[0] = 32'h40;
    cf[1] = mk(M_TOR, RD|WR, 1'b0);   ad[1] = 32'h80;
    probe(34'h10, 34'd4, RD, PU, 1'b1, "R3 tor entry0 read");
    probe(34'h10, 34'd4, WR, PU, 1'b0, "R9 tor entry0 write denied");
    probe(34'h100, 34'd4, WR, PU, 1'b1, "R3 tor entry1 uses prev reg");
    probe(34'h200, 34'd4, RD, PU, 1'b0, "R11 user no match denied");
    probe(34'h200, 34'd4, RD, PM, 1'b1, "R11 machine no match allowed");
    clear_ents();
    cf[0] = mk(M_TOR, 3'b000, 1'b0);  ad[0] = '0;
    cf[1] = mk(M_NAPOT, 3'b111, 1'b0); ad[1] = '1;
    probe(34'h10, 34'd4, RD, PU, 1'b1, "R3 empty tor matches nothing");
  endtask

  task automatic t_na4();
    clear_ents();
    cf[0] = mk(M_NA4, EX, 1'b0); ad[0] = 32'h50;
    probe(34'h140, 34'd4, EX, PU, 1'b1, "R4 na4 exact");
    probe(34'h144, 34'd4, EX, PU, 1'b0, "R4 na4 next word outside");
    probe(34'h142, 34'd4, EX, PU, 1'b0, "R8 na4 partial user");
    probe(34'h142, 34'd4, RD, PM, 1'b0, "R8 na4 partial machine");
  endtask

  task automatic t_napot();
    clear_ents();
    cf[0] = mk(M_NAPOT, RD, 1'b0); ad[0] = 32'h101; // 0x400..0x40F
    probe(34'h40C, 34'd4, RD, PU, 1'b1, "R5 napot16 inside");
    probe(34'h410, 34'd4, RD, PU, 1'b0, "R5 napot16 above");
    probe(34'h3FC, 34'd4, RD, PU, 1'b0, "R5 napot16 below");
    probe(34'h40E, 34'd4, RD, PU, 1'b0, "R8 napot16 straddle");
    ad[0] = '1;
    probe(34'h3_FFFF_FFF0, 34'd4, RD, PU, 1'b1, "R5 all ones whole space");
    probe(34'h3_FFFF_FFF0, 34'd4, WR, PU, 1'b0, "R9 all ones write denied");
  endtask

  task automatic t_size0();
    clear_ents();
    cf[0] = mk(M_NAPOT, RD, 1'b0); ad[0] = 32'h5FF; // 0x1000..0x1FFF
    probe(34'h1800, 34'd0, RD, PU, 1'b1, "R6 size0 to page end inside");
    ad[0] = 32'h4FF; // 0x1000..0x17FF
    probe(34'h1000, 34'd0, RD, PU, 1'b0, "R6 size0 crosses region end");
    probe(34'h1000, 34'd4, RD, PU, 1'b1, "R6 size4 inside half page");
  endtask

  task automatic t_prio();
    clear_ents();
    cf[0] = mk(M_NA4, RD, 1'b0);       ad[0] = 32'h50;
    cf[1] = mk(M_NAPOT, 3'b111, 1'b0); ad[1] = '1;
    probe(34'h140, 34'd4, WR, PU, 1'b0, "R7 low entry wins deny");
    probe(34'h200, 34'd4, WR, PU, 1'b1, "R7 falls to entry1");
    cf[0] = mk(M_NA4, 3'b111, 1'b0); cf[1] = mk(M_NAPOT, 3'b000, 1'b0);
    probe(34'h140, 34'd4, WR, PU, 1'b1, "R7 low entry wins allow");
  endtask

  task automatic t_mlock();
    clear_ents();
    cf[0] = mk(M_NA4, 3'b000, 1'b0); ad[0] = 32'h50;
    probe(34'h140, 34'd4, RD|WR|EX, PM, 1'b1, "R10 machine unlocked all rights");
    probe(34'h140, 34'd4, RD, PU, 1'b0, "R9 user no rights");
    cf[0] = mk(M_NA4, 3'b000, 1'b1);
    probe(34'h140, 34'd4, RD, PM, 1'b0, "R10 machine own lock");
    clear_ents();
    cf[0] = mk(M_TOR, 3'b000, 1'b0); ad[0] = 32'h40;
    cf[1] = mk(M_TOR, 3'b000, 1'b1); ad[1] = 32'h80;
    probe(34'h10, 34'd4, RD, PM, 1'b0, "R10 lock from next tor entry");
    cf[1] = mk(M_NA4, 3'b000, 1'b1);
    probe(34'h10, 34'd4, RD, PM, 1'b1, "R10 next lock non-tor ignored");
  endtask

  task automatic t_latency();
    clear_ents();
    probe(34'h10, 34'd4, RD, PU, 1'b1, "R12 setup allow");
    cf[0] = mk(M_NA4, 3'b000, 1'b0); ad[0] = 32'h4;
    @(negedge clk);
    drive(34'h10, 34'd4, RD, PU);
    #1;
    check(1'b1, "R12 output holds before edge");
    @(posedge clk);
    @(negedge clk);
    check(1'b0, "R12 output after one edge");
  endtask

  initial begin
    clear_ents();
    drive('0, '0, '0, '0);
    t_reset();
    t_none();
    t_tor();
    t_na4();
    t_napot();
    t_size0();
    t_prio();
    t_mlock();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule